// File: doc/BRIEF.md
# Non-Volatile Page Recall Sequencer for a DAC Bank

This block restores a bank of DAC channel registers from one page of a non-volatile store. When a restore starts, it walks every channel from the first to the last and never skips or reorders one. For each channel it issues a read of the stored word and writes that word into the matching DAC register.

Three sources can start a restore. The first is a power-up auto-read request. The second is a qualified pulse on an external recall pin, with the page taken from two page-select pins. The third is a single-cycle command request that carries its own page. While a restore runs the block raises `busy`. At the end it emits a one-cycle `done`. After a restore started from the recall pin, it also pulses `prog_dis` so the surrounding logic drops its write-enable permission for the store.

A short recall pulse is treated as a glitch and ignored. A recall pulse that lands too soon after the previous restore is also ignored. All inputs are expected to be synchronous to `clk`.

Top module: `recall_seq`

## Requirements
- R1: A power-up request (`por_req`), a qualified recall-pin pulse, or a command request (`cmd_req`) each start one full restore when the block is idle. When several arrive in the same cycle, power-up wins over the recall pin, and the recall pin wins over the command.
- R2: Channels are restored in order from index 0 up to NCH-1.
  - `dac_sel` carries the channel index.
  - `ee_rd_addr` is `{page, channel}`, with the channel in the low $clog2(NCH) bits.
  - The store answers one cycle after `ee_rd_en`. The word written on `dac_wdata` is the word read for that same channel.
- R3: The page is latched when the restore is triggered and held for the whole restore.
  - For the recall pin, the page is `pin_page` sampled in the cycle the pin rises.
  - For power-up, the page is `pin_page` in the request cycle.
  - For the command, the page is `cmd_page`.
- R4: A recall-pin pulse starts a restore only at its falling edge, and only if the pin was high for at least MIN_PULSE clock cycles. Shorter pulses cause no DAC write.
- R5: Triggers are refused in two cases, and neither causes any DAC write:
  - any trigger that arrives while a restore is running;
  - a recall-pin falling edge that arrives within LOCKOUT cycles after `done`.
- R6: `busy` is high for exactly 2*NCH cycles per restore. `done` is a one-cycle pulse in the cycle after the last channel write, and `busy` is low in that cycle.
- R7: `prog_dis` pulses together with `done` only when the restore was started by the recall pin.
- R8: Out of reset, `busy`, `done`, `prog_dis`, `ee_rd_en` and `dac_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_req | input | 1 | Power-up auto-read request, one cycle |
| recall_pin | input | 1 | External recall pulse, synchronised |
| pin_page | input | PW | Page-select pins |
| cmd_req | input | 1 | Restore-all command request, one cycle |
| cmd_page | input | PW | Page carried by the command |
| ee_rd_en | output | 1 | Store read request |
| ee_rd_addr | output | PW+$clog2(NCH) | Store word address {page, channel} |
| ee_rd_data | input | DW | Store read data, valid one cycle after request |
| dac_we | output | 1 | DAC register write strobe |
| dac_sel | output | $clog2(NCH) | DAC channel index |
| dac_wdata | output | DW | DAC register write data |
| busy | output | 1 | Restore in progress |
| done | output | 1 | One-cycle end-of-restore pulse |
| prog_dis | output | 1 | Drop store programming permission |

## Verification
The bench changes `pin_page` while the recall pin is still high. A design that samples the page late would restore the wrong page. It sends pulses one cycle shorter than the minimum width and a pulse whose falling edge falls inside the lockout; a design with an off-by-one width or lockout check would write all twelve channels where none is expected. It fires a power-up request and a command in the same cycle, and separately a recall falling edge and a command in the same cycle. A wrong priority shows up as the other page and a missing or spurious `prog_dis`. It also fires triggers in the middle of a running restore, which a design lacking the busy guard would answer with a second restore or a switch of page.

// File: rtl/recall_seq_pkg.sv
package recall_seq_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_RD   = 2'd1,
        WALK_WR   = 2'd2
    } walk_state_t;

endpackage

// File: rtl/recall_trigger.sv
module recall_trigger #(
    parameter int PW        = 2,
    parameter int MIN_PULSE = 3,
    parameter int LOCKOUT   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_req,
    input  logic          pin_in,
    input  logic [PW-1:0] pin_page,
    input  logic          cmd_req,
    input  logic [PW-1:0] cmd_page,
    input  logic          busy,
    input  logic          done,
    output logic          start_o,
    output logic [PW-1:0] start_page_o,
    output logic          start_pin_o
);
    localparam int PCW = $clog2(MIN_PULSE + 1);
    localparam int LKW = $clog2(LOCKOUT + 1);

    typedef struct packed {
        logic           prev;
        logic [PCW-1:0] pcnt;
        logic [PW-1:0]  cpage;
        logic [LKW-1:0] lock;
        logic           start;
        logic [PW-1:0]  spage;
        logic           spin;
    } trig_t;

    trig_t q, d;
    logic  fall, pin_ok, idle;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.prev  = pin_in;
        // measure pulse width, latch page at the rising edge (R3, R4)
        if (pin_in && !q.prev) begin
            d.pcnt  = PCW'(1);
            d.cpage = pin_page;
        end else if (pin_in && q.pcnt < PCW'(MIN_PULSE)) begin
            d.pcnt = q.pcnt + PCW'(1);
        end
        // re-trigger lockout window (R5)
        if (done) begin
            d.lock = LKW'(LOCKOUT);
        end else if (q.lock != '0) begin
            d.lock = q.lock - LKW'(1);
        end
        fall   = !pin_in && q.prev;
        pin_ok = fall && (q.pcnt >= PCW'(MIN_PULSE)) && (q.lock == '0);
        idle   = !busy && !q.start && !done;
        // priority: power-up, then recall pin, then command (R1)
        if (idle) begin
            if (por_req) begin
                d.start = 1'b1;
                d.spage = pin_page;
                d.spin  = 1'b0;
            end else if (pin_ok) begin
                d.start = 1'b1;
                d.spage = q.cpage;
                d.spin  = 1'b1;
            end else if (cmd_req) begin
                d.start = 1'b1;
                d.spage = cmd_page;
                d.spin  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign start_o      = q.start;
    assign start_page_o = q.spage;
    assign start_pin_o  = q.spin;

    assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    assert_no_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start_o);
    assert_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lock != '0 && fall && !por_req && !cmd_req) |=> !start_o);
    assert_short_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && q.pcnt < PCW'(MIN_PULSE) && !por_req && !cmd_req) |=> !start_o);

endmodule

// File: rtl/recall_walker.sv
module recall_walker
    import recall_seq_pkg::*;
#(
    parameter int NCH = 12,
    parameter int DW  = 8,
    parameter int PW  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [PW-1:0]             start_page,
    input  logic                      start_pin,
    output logic                      ee_rd_en,
    output logic [PW+$clog2(NCH)-1:0] ee_rd_addr,
    input  logic [DW-1:0]             ee_rd_data,
    output logic                      dac_we,
    output logic [$clog2(NCH)-1:0]    dac_sel,
    output logic [DW-1:0]             dac_wdata,
    output logic                      busy,
    output logic                      done,
    output logic                      prog_dis
);
    localparam int CW = $clog2(NCH);
    localparam int AW = PW + CW;

    typedef struct packed {
        walk_state_t   state;
        logic [CW-1:0] ch;
        logic [PW-1:0] page;
        logic          pin;
        logic          done;
        logic          prog_dis;
    } walk_t;

    walk_t q, d;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.prog_dis = 1'b0;
        unique case (q.state)
            WALK_IDLE: begin
                if (start) begin
                    d.state = WALK_RD;
                    d.ch    = '0;
                    d.page  = start_page;
                    d.pin   = start_pin;
                end
            end
            WALK_RD: d.state = WALK_WR;
            WALK_WR: begin
                if (q.ch == CW'(NCH - 1)) begin
                    d.state    = WALK_IDLE;
                    d.done     = 1'b1;
                    d.prog_dis = q.pin;
                end else begin
                    d.ch    = q.ch + CW'(1);
                    d.state = WALK_RD;
                end
            end
            default: d.state = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ee_rd_en   = (q.state == WALK_RD);
    assign ee_rd_addr = {q.page, q.ch};
    assign dac_we     = (q.state == WALK_WR);
    assign dac_sel    = q.ch;
    assign dac_wdata  = ee_rd_data;
    assign busy       = (q.state != WALK_IDLE);
    assign done       = q.done;
    assign prog_dis   = q.prog_dis;

    assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dac_we |-> ($past(ee_rd_en) && dac_sel == $past(ee_rd_addr[CW-1:0])));
    assert_channel_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_we && dac_sel != '0) |-> (dac_sel == $past(dac_sel, 2) + CW'(1)));
    assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ee_rd_addr[AW-1:CW]));
    assert_done_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(dac_we) && $past(dac_sel) == CW'(NCH - 1)));
    assert_prog_dis_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_dis |-> done);
    assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ee_rd_en, dac_we}));

endmodule

// File: rtl/recall_seq.sv
module recall_seq #(
    parameter int NCH       = 12,
    parameter int DW        = 8,
    parameter int PW        = 2,
    parameter int MIN_PULSE = 3,
    parameter int LOCKOUT   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      por_req,
    input  logic                      recall_pin,
    input  logic [PW-1:0]             pin_page,
    input  logic                      cmd_req,
    input  logic [PW-1:0]             cmd_page,
    output logic                      ee_rd_en,
    output logic [PW+$clog2(NCH)-1:0] ee_rd_addr,
    input  logic [DW-1:0]             ee_rd_data,
    output logic                      dac_we,
    output logic [$clog2(NCH)-1:0]    dac_sel,
    output logic [DW-1:0]             dac_wdata,
    output logic                      busy,
    output logic                      done,
    output logic                      prog_dis
);
    logic          start;
    logic [PW-1:0] start_page;
    logic          start_pin;

    recall_trigger #(
        .PW(PW), .MIN_PULSE(MIN_PULSE), .LOCKOUT(LOCKOUT)
    ) u_trigger (
        .clk(clk), .rst_n(rst_n),
        .por_req(por_req), .pin_in(recall_pin), .pin_page(pin_page),
        .cmd_req(cmd_req), .cmd_page(cmd_page),
        .busy(busy), .done(done),
        .start_o(start), .start_page_o(start_page), .start_pin_o(start_pin)
    );

    recall_walker #(
        .NCH(NCH), .DW(DW), .PW(PW)
    ) u_walker (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_page(start_page), .start_pin(start_pin),
        .ee_rd_en(ee_rd_en), .ee_rd_addr(ee_rd_addr), .ee_rd_data(ee_rd_data),
        .dac_we(dac_we), .dac_sel(dac_sel), .dac_wdata(dac_wdata),
        .busy(busy), .done(done), .prog_dis(prog_dis)
    );

    assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done && !prog_dis));

endmodule

// File: tb/recall_seq_tb.sv
module recall_seq_tb;
    localparam int NCH = 12;
    localparam int DW  = 8;
    localparam int PW  = 2;
    localparam int CW  = $clog2(NCH);
    localparam int AW  = PW + CW;
    localparam int NV  = 8;
    // vector table: source (0 power-up, 1 recall pin, 2 command), page, pulse width, restore expected
    localparam int VSRC  [NV] = '{1, 1, 1, 1, 0, 2, 2, 1};
    localparam int VPAGE [NV] = '{0, 1, 2, 3, 2, 3, 1, 3};
    localparam int VW    [NV] = '{3, 5, 2, 1, 0, 0, 0, 4};
    localparam int VRUN  [NV] = '{1, 1, 0, 0, 1, 1, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_req = 1'b0, recall_pin = 1'b0, cmd_req = 1'b0;
    logic [PW-1:0] pin_page = '0, cmd_page = '0;
    logic ee_rd_en, dac_we, busy, done, prog_dis;
    logic [AW-1:0] ee_rd_addr;
    logic [DW-1:0] ee_rd_data = '0, dac_wdata;
    logic [CW-1:0] dac_sel;

    int checks = 0, errors = 0;
    int wr_cnt = 0, order_err = 0, busy_cnt = 0, done_cnt = 0, clr_cnt = 0, overlap = 0;
    logic [DW-1:0] dac_model [NCH];
    bit finished = 0;

    always #5 clk = ~clk;

    recall_seq u_dut (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .recall_pin(recall_pin),
        .pin_page(pin_page), .cmd_req(cmd_req), .cmd_page(cmd_page),
        .ee_rd_en(ee_rd_en), .ee_rd_addr(ee_rd_addr), .ee_rd_data(ee_rd_data),
        .dac_we(dac_we), .dac_sel(dac_sel), .dac_wdata(dac_wdata),
        .busy(busy), .done(done), .prog_dis(prog_dis)
    );

    function automatic logic [DW-1:0] memval(int p, int c);
        return DW'((p * 53 + c * 17 + 9) % 256);
    endfunction

    always @(posedge clk) begin
        if (ee_rd_en) ee_rd_data <= memval(int'(ee_rd_addr[AW-1:CW]), int'(ee_rd_addr[CW-1:0]));
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (dac_we) begin
                if (int'(dac_sel) != wr_cnt % NCH) order_err++;
                if (int'(dac_sel) < NCH) dac_model[dac_sel] = dac_wdata;
                wr_cnt++;
            end
            if (busy) busy_cnt++;
            if (done) done_cnt++;
            if (prog_dis) clr_cnt++;
            if (done && busy) overlap++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(posedge clk);
        wr_cnt = 0; order_err = 0; busy_cnt = 0; done_cnt = 0; clr_cnt = 0; overlap = 0;
        for (int c = 0; c < NCH; c++) dac_model[c] = 8'hEE;
    endtask

    task automatic pin_pulse(input int pg, input int w);
        @(negedge clk);
        pin_page = PW'(pg);
        recall_pin = 1'b1;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            pin_page = PW'(pg ^ 3);
        end
        recall_pin = 1'b0;
    endtask

    task automatic por_pulse(input int pg);
        @(negedge clk);
        pin_page = PW'(pg);
        por_req = 1'b1;
        @(negedge clk);
        por_req = 1'b0;
        pin_page = PW'(pg ^ 3);
    endtask

    task automatic cmd_pulse(input int pg);
        @(negedge clk);
        cmd_page = PW'(pg);
        pin_page = PW'(pg ^ 3);
        cmd_req = 1'b1;
        @(negedge clk);
        cmd_req = 1'b0;
    endtask

    task automatic settle_and_check(input int pg, input bit run, input bit clr, input string tag);
        repeat (40) @(negedge clk);
        @(posedge clk);
        chk(wr_cnt == (run ? NCH : 0), {tag, " R1/R4/R5 write count"}, wr_cnt, run ? NCH : 0);
        chk(order_err == 0, {tag, " R2 order"}, order_err, 0);
        if (run) begin
            for (int c = 0; c < NCH; c++)
                chk(dac_model[c] == memval(pg, c), {tag, " R3 data/page"}, int'(dac_model[c]), int'(memval(pg, c)));
        end
        chk(busy_cnt == (run ? 2 * NCH : 0), {tag, " R6 busy length"}, busy_cnt, run ? 2 * NCH : 0);
        chk(done_cnt == (run ? 1 : 0) && overlap == 0, {tag, " R6 done pulse"}, done_cnt, run ? 1 : 0);
        chk(clr_cnt == (clr ? 1 : 0), {tag, " R7 prog_dis"}, clr_cnt, clr ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) dac_model[c] = 8'hEE;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(!busy, "R8 busy", int'(busy), 0);
        chk(!done && !prog_dis, "R8 done/prog_dis", int'(done), 0);
        chk(!ee_rd_en && !dac_we, "R8 strobes", int'(dac_we), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !dac_we, "R8 idle after reset", int'(busy), 0);

        // vector table walk
        for (int v = 0; v < NV; v++) begin
            clear_counts();
            case (VSRC[v])
                0: por_pulse(VPAGE[v]);
                1: pin_pulse(VPAGE[v], VW[v]);
                default: cmd_pulse(VPAGE[v]);
            endcase
            settle_and_check(VPAGE[v], VRUN[v] != 0, VSRC[v] == 1 && VRUN[v] != 0,
                             $sformatf("vec%0d", v));
        end

        // R1 priority: power-up over command in the same cycle
        clear_counts();
        @(negedge clk);
        pin_page = 2'd1; por_req = 1'b1; cmd_req = 1'b1; cmd_page = 2'd2;
        @(negedge clk);
        por_req = 1'b0; cmd_req = 1'b0; pin_page = 2'd3;
        settle_and_check(1, 1'b1, 1'b0, "prio_por_cmd R1");

        // R1 priority: recall falling edge over command in the same cycle
        clear_counts();
        @(negedge clk);
        pin_page = 2'd3; recall_pin = 1'b1;
        repeat (3) @(negedge clk);
        recall_pin = 1'b0; cmd_req = 1'b1; cmd_page = 2'd0;
        @(negedge clk);
        cmd_req = 1'b0;
        settle_and_check(3, 1'b1, 1'b1, "prio_pin_cmd R1");

        // R5 triggers during a running restore are refused
        clear_counts();
        cmd_pulse(1);
        repeat (6) @(negedge clk);
        pin_page = 2'd2; por_req = 1'b1; cmd_req = 1'b1; cmd_page = 2'd3;
        @(negedge clk);
        por_req = 1'b0; cmd_req = 1'b0;
        settle_and_check(1, 1'b1, 1'b0, "busy_ignore R5");

        // R5 lockout after done
        clear_counts();
        pin_pulse(0, 3);
        while (done_cnt == 0) @(posedge clk);
        clear_counts();
        pin_pulse(2, 3);
        settle_and_check(2, 1'b0, 1'b0, "lockout R5");
        clear_counts();
        pin_pulse(2, 3);
        settle_and_check(2, 1'b1, 1'b1, "after_lockout R5");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule